// File: doc/BRIEF.md
# Second-Level Cache Error Logger

This unit gathers error-detection pulses from the second-level cache and memory datapath into eleven sticky status flags, one for each error class. A flag stays set until software writes a 1 to its position. As long as any flag is set and the trap-disable input is low, the unit asks the processor for a trap.

Next to the flags, a fault-address register holds the physical address of the most important error seen so far, together with a priority field. Each error class has a fixed capture priority, and some classes have none. A new error overwrites the register only when its priority is strictly greater than the stored field. Software reads the three registers through a small read/write port. Writing 0 to the priority field reopens capture.

Top module: `l2_err_log`

## Requirements
- R1: A pulse on `err_vld_i[i]` sets status bit i on the next clock edge, and the bit stays set while no clear reaches it.
- R2: A register write with `reg_sel_i`=0 clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged. If a detection and a clear hit the same bit in the same cycle, the bit ends up set.
- R3: `trap_o` is 1 when at least one status bit is 1 and `trap_dis_i` is 0. Otherwise it is 0.
- R4: The capture priorities are fixed per class. Class 0 has 30, class 1 has 28, class 3 has 24, class 4 has 20, class 9 (correctable incoming data) has 16, class 5 has 12, class 6 has 8, class 7 has 4 and class 8 has 2. When the winning priority P of a cycle is greater than the stored field, the address register takes that error's address and the field becomes P.
- R5: When P is less than or equal to the stored field, the address register and the field keep their values. This includes the case where P equals the stored field.
- R6: Class 10 (way-reduction degradation) and class 2 have no capture priority. They set their status bits but never change the address register or the field.
- R7: When several classes pulse in the same cycle, all of their status bits are set. Only the highest-priority class among them is compared and captured. On equal priority, the lower class index wins.
- R8: The priority field resets to 0. A write with `reg_sel_i`=2 loads it from data bits [4:0]. If a capture happens in the same cycle, the capture wins.
- R9: The register read map is: `reg_sel_i`=0 gives the status in bits [10:0]; 1 gives the fault address with bits [2:0] forced to 0 (doubleword resolution); 2 gives the field in bits [4:0]; 3 gives 0. All registers reset to 0, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_vld_i | input | 11 | One detection pulse per error class |
| err_addr_i | input | 11x40 | Physical address for each class, packed with class i in slice i |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data for the selected register |
| trap_dis_i | input | 1 | Trap-disable condition |
| trap_o | output | 1 | Trap request |

## Verification
Every state change is due one clock edge after the cycle in which a pulse or write is presented. Reads and the trap output follow that state combinationally in the same cycle. Each stimulus task drives its inputs for exactly one cycle, from one falling edge to the next. The monitor then samples every register and the trap output at that falling edge, a single rising edge later, so each result is compared in the cycle it first appears. Same-cycle collisions, between a detection and a clear and between a capture and a priority write, are driven in one cycle so that the ordering rule itself is what gets checked.

// File: rtl/err_log_pkg.sv
package err_log_pkg;
  localparam int PRIO_W = 5;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_PRIO = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;

  // 0 means the class never captures an address
  function automatic logic [PRIO_W-1:0] class_prio(input int idx);
    case (idx)
      0:       return 5'd30;
      1:       return 5'd28;
      3:       return 5'd24;
      4:       return 5'd20;
      5:       return 5'd12;
      6:       return 5'd8;
      7:       return 5'd4;
      8:       return 5'd2;
      9:       return 5'd16;
      default: return 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/err_sticky.sv
module err_sticky #(
  parameter int N_CLS = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CLS-1:0] set_i,
  input  logic [N_CLS-1:0] clr_i,
  output logic [N_CLS-1:0] stat_o
);
  logic [N_CLS-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | set_i;  // set beats clear
  end

  assign stat_o = stat_q;

  p_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((stat_q & $past(set_i)) == $past(set_i)));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr_i)) == $past(stat_q & ~clr_i)));

  p_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((stat_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/err_prio_pick.sv
module err_prio_pick
  import err_log_pkg::*;
#(
  parameter int N_CLS  = 11,
  parameter int ADDR_W = 40
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_CLS-1:0]             vld_i,
  input  logic [N_CLS-1:0][ADDR_W-1:0] addr_i,
  output logic                         win_vld_o,
  output logic [PRIO_W-1:0]            win_prio_o,
  output logic [ADDR_W-1:0]            win_addr_o
);
  always_comb begin
    win_vld_o  = 1'b0;
    win_prio_o = '0;
    win_addr_o = '0;
    // strict compare keeps the lowest index on ties
    for (int i = 0; i < N_CLS; i++) begin
      if (vld_i[i] && (class_prio(i) > win_prio_o)) begin
        win_vld_o  = 1'b1;
        win_prio_o = class_prio(i);
        win_addr_o = addr_i[i];
      end
    end
  end

  for (genvar g = 0; g < N_CLS; g++) begin : g_chk
    if (class_prio(g) != 0) begin : g_pri
      p_pick_max_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_i[g] |-> (win_vld_o && (win_prio_o >= class_prio(g))));
    end else begin : g_none
      p_no_prio_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_i == (N_CLS'(1) << g)) |-> !win_vld_o);
    end
  end
endmodule

// File: rtl/fault_addr_cap.sv
module fault_addr_cap
  import err_log_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win_vld_i,
  input  logic [PRIO_W-1:0] win_prio_i,
  input  logic [ADDR_W-1:0] win_addr_i,
  input  logic              sw_we_i,
  input  logic [PRIO_W-1:0] sw_prio_i,
  output logic [ADDR_W-4:0] dw_addr_o,
  output logic [PRIO_W-1:0] prio_o
);
  logic [ADDR_W-4:0] dw_addr_q;
  logic [PRIO_W-1:0] prio_q;
  logic              cap;

  assign cap = win_vld_i && (win_prio_i > prio_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dw_addr_q <= '0;
      prio_q    <= '0;
    end else if (cap) begin
      dw_addr_q <= win_addr_i[ADDR_W-1:3];
      prio_q    <= win_prio_i;
    end else if (sw_we_i) begin
      prio_q    <= sw_prio_i;
    end
  end

  assign dw_addr_o = dw_addr_q;
  assign prio_o    = prio_q;

  p_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_vld_i && (win_prio_i > prio_q)) |=>
      ((prio_q == $past(win_prio_i)) && (dw_addr_q == $past(win_addr_i[ADDR_W-1:3]))));

  p_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_we_i && !(win_vld_i && (win_prio_i > prio_q))) |=>
      ($stable(prio_q) && $stable(dw_addr_q)));

  p_sw_prio_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_we_i && !win_vld_i) |=> (prio_q == $past(sw_prio_i)));
endmodule

// File: rtl/l2_err_log.sv
module l2_err_log
  import err_log_pkg::*;
#(
  parameter int N_CLS  = 11,
  parameter int ADDR_W = 40,
  parameter int DATA_W = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_CLS-1:0]             err_vld_i,
  input  logic [N_CLS-1:0][ADDR_W-1:0] err_addr_i,
  input  logic                         reg_we_i,
  input  logic [1:0]                   reg_sel_i,
  input  logic [DATA_W-1:0]            reg_wdata_i,
  output logic [DATA_W-1:0]            reg_rdata_o,
  input  logic                         trap_dis_i,
  output logic                         trap_o
);
  logic [N_CLS-1:0]  stat, clr;
  logic              win_vld, prio_we;
  logic [PRIO_W-1:0] win_prio, prio;
  logic [ADDR_W-1:0] win_addr;
  logic [ADDR_W-4:0] dw_addr;
  reg_sel_e          sel;

  assign sel     = reg_sel_e'(reg_sel_i);
  assign clr     = (reg_we_i && sel == SEL_STAT) ? reg_wdata_i[N_CLS-1:0] : '0;
  assign prio_we = reg_we_i && (sel == SEL_PRIO);

  err_sticky #(.N_CLS(N_CLS)) u_sticky (
    .clk_i, .rst_ni, .set_i(err_vld_i), .clr_i(clr), .stat_o(stat)
  );

  err_prio_pick #(.N_CLS(N_CLS), .ADDR_W(ADDR_W)) u_pick (
    .clk_i, .rst_ni, .vld_i(err_vld_i), .addr_i(err_addr_i),
    .win_vld_o(win_vld), .win_prio_o(win_prio), .win_addr_o(win_addr)
  );

  fault_addr_cap #(.ADDR_W(ADDR_W)) u_cap (
    .clk_i, .rst_ni, .win_vld_i(win_vld), .win_prio_i(win_prio),
    .win_addr_i(win_addr), .sw_we_i(prio_we), .sw_prio_i(reg_wdata_i[PRIO_W-1:0]),
    .dw_addr_o(dw_addr), .prio_o(prio)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      SEL_STAT: reg_rdata_o[N_CLS-1:0]  = stat;
      SEL_ADDR: reg_rdata_o[ADDR_W-1:3] = dw_addr;
      SEL_PRIO: reg_rdata_o[PRIO_W-1:0] = prio;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign trap_o = (|stat) && !trap_dis_i;

  p_trap_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_dis_i && $past(|err_vld_i)) |-> trap_o);

  p_trap_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_dis_i |-> !trap_o);
endmodule

// File: tb/sim_l2_err_log.sv
`timescale 1ns/1ps
module sim_l2_err_log;
  localparam int N = 11, AW = 40, DW = 64;

  logic               clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0]       vld = '0;
  logic [N-1:0][AW-1:0] addr;
  logic               we = 1'b0, dis = 1'b0, drv_act = 1'b0;
  logic [1:0]         drv_sel = '0, mon_sel = '0, sel;
  logic [DW-1:0]      wdata = '0, rdata;
  logic               trap;

  assign sel = drv_act ? drv_sel : mon_sel;

  always #2 clk = ~clk;

  l2_err_log #(.N_CLS(N), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .err_vld_i(vld), .err_addr_i(addr),
    .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .trap_dis_i(dis), .trap_o(trap)
  );

  typedef struct { int sel; logic [DW-1:0] exp; string tag; } item_t;
  item_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  logic [N-1:0]  m_stat = '0;
  logic [4:0]    m_prio = '0;
  logic [AW-1:0] m_addr = '0;

  function automatic logic [4:0] ref_prio(int i);
    case (i)
      0: return 30; 1: return 28; 3: return 24; 4: return 20; 9: return 16;
      5: return 12; 6: return 8;  7: return 4;  8: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [AW-1:0] addr_for(int i);
    return 40'h12_3456_7800 + AW'(i) * 40'h1b0 + 40'h5;
  endfunction

  task automatic push_all(string tag);
    item_t it;
    it.tag = tag;
    it.sel = 0; it.exp = DW'(m_stat);         q.push_back(it);
    it.sel = 1; it.exp = DW'(m_addr & ~40'h7); q.push_back(it);
    it.sel = 2; it.exp = DW'(m_prio);         q.push_back(it);
    it.sel = 4; it.exp = DW'((|m_stat) && !dis); q.push_back(it);
    wait (q.size() == 0);
  endtask

  // one-cycle stimulus: pulses, optional register write
  task automatic step(logic [N-1:0] mask, logic w, logic [1:0] s,
                      logic [DW-1:0] d, string tag);
    logic [4:0] best = 0;
    int bi = 0;
    logic [N-1:0] c;
    @(negedge clk);
    vld = mask; we = w; drv_sel = s; wdata = d; drv_act = 1'b1;
    @(negedge clk);
    vld = '0; we = 1'b0; drv_act = 1'b0;
    c = (w && s == 2'd0) ? d[N-1:0] : '0;
    m_stat = (m_stat & ~c) | mask;
    for (int i = 0; i < N; i++)
      if (mask[i] && ref_prio(i) > best) begin best = ref_prio(i); bi = i; end
    if (best > m_prio) begin m_prio = best; m_addr = addr_for(bi); end
    else if (w && s == 2'd2) m_prio = d[4:0];
    push_all(tag);
  endtask

  initial begin : monitor
    item_t it;
    logic [DW-1:0] act;
    forever begin
      wait (q.size() != 0);
      it = q[0];
      mon_sel = (it.sel < 4) ? it.sel[1:0] : 2'd0;
      #0.5;
      act = (it.sel == 4) ? DW'(trap) : rdata;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
      end
      void'(q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < N; i++) addr[i] = addr_for(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push_all("R9 reset state");
    step(11'h200, 0, 0, 0, "R1 R4 class9 capture");
    dis = 1'b1;
    push_all("R3 trap disabled");
    dis = 1'b0;
    push_all("R3 trap re-enabled");
    step(11'h020, 0, 0, 0, "R5 lower prio ignored");
    step(11'h200, 0, 0, 0, "R5 equal prio ignored");
    step(11'h404, 0, 0, 0, "R6 no-prio classes");
    step(11'h008, 0, 0, 0, "R4 higher prio capture");
    step(11'h000, 1, 0, 0, "R2 write zero no effect");
    step(11'h000, 1, 0, 64'h200, "R2 clear class9");
    step(11'h010, 1, 0, 64'h010, "R2 set wins over clear");
    step(11'h000, 1, 2'd3, 64'h1f, "R9 reserved reg");
    step(11'h0c3, 0, 0, 0, "R7 simultaneous pick");
    step(11'h000, 1, 2, 0, "R8 reopen capture");
    step(11'h100, 0, 0, 0, "R8 low prio after reopen");
    step(11'h080, 1, 2, 64'h1, "R8 capture beats write");
    step(11'h000, 1, 2, 64'h1f, "R8 sw prio write");
    step(11'h001, 0, 0, 0, "R5 blocked by high field");
    step(11'h402, 0, 0, 0, "R7 R6 mixed pulse");
    step(11'h000, 1, 0, 64'h7ff, "R3 clear all drops trap");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule